// File: doc/BRIEF.md
# Banked Masked-Write Control Register File

This block holds the system-control registers of a multithreaded core. A register is named by a 5-bit register number and a 3-bit select, which together form a flat index (number times 8 plus select). Each implemented register has a fixed bank kind. A shared register has one copy. A per-thread register has one copy for each thread context. A per-virtual-processor register has one copy for each virtual processor. Every access carries a thread ID, and that ID picks the copy. For per-virtual-processor registers the copy is picked by the processor field of the accessing thread's binding register.

Each register has its own write mask. A normal write changes only the bits its mask marks writable and keeps the rest. A second, raw write path stores the whole word and ignores the mask. Reads are combinational. Writes land on the clock edge. Reset loads fixed values into every copy.

Top module: `ctlrf_top`

## Requirements
- R1: After reset the register values are as follows. machState is 0x00400004 in every thread. vecBase is 0x80000000 in every processor copy. threadBind holds the thread's own number in bits [28:21]. All other registers are 0.
- R2: The flat index is {regNum, sel}. The implemented registers and their (regNum, sel) pairs are: slotIdx (0,0), threadBind (2,2), machState (12,0), intCfg (12,1), vecBase (15,1), cfgMain (16,0) and cfgRo (16,1).
- R3: A normal write stores (wrData AND mask) OR (old AND NOT mask). The masks are: slotIdx 0x7FFFFFFF, machState 0xFF78FF17, intCfg 0x000003E0, vecBase 0x3FFFF000, cfgMain 0x7FFF0007, cfgRo 0. For threadBind the mask is the low VPE_W bits, where VPE_W is the larger of 1 and clog2(NUM_VPES).
- R4: A write with wrRaw=1 stores wrData unmasked into the selected copy.
- R5: machState and threadBind are per-thread. A write by thread t changes only copy t.
- R6: cfgMain and vecBase are per-virtual-processor. The copy is given by bits [VPE_W-1:0] of the accessing thread's threadBind. A field value of NUM_VPES or more selects copy 0.
- R7: slotIdx, intCfg and cfgRo are shared. A write from any thread is seen by every thread.
- R8: A read returns the selected copy in the same cycle. A write shows from the next cycle on, so a read in the cycle of the write returns the old value.
- R9: A read of an unimplemented index, or with a thread ID of NUM_THREADS or more, returns 0. A write to either changes nothing.
- R10: A normal write to cfgRo leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdThread | input | TID_W | Thread ID of the read |
| rdRegNum | input | 5 | Register number of the read |
| rdSel | input | 3 | Select of the read |
| rdData | output | 32 | Read value |
| wrEn | input | 1 | Write strobe |
| wrRaw | input | 1 | 1 = store unmasked |
| wrThread | input | TID_W | Thread ID of the write |
| wrRegNum | input | 5 | Register number of the write |
| wrSel | input | 3 | Select of the write |
| wrData | input | 32 | Write value |

## Verification
The bench builds the block with four threads and two virtual processors. With this setup, two threads can bind to different processor copies and two other threads can share one. It can also show that a per-thread write from one thread does not reach another thread's copy. The default of a single virtual processor would hide the copy selection through the binding field entirely.

// File: rtl/ctlrf_pkg.sv
package ctlrf_pkg;
  localparam int DW = 32;
  localparam int IDX_W = 8;
  localparam int SLOT_W = 8;
  localparam int NUM_REGS = 7;
  localparam int BIND_REG = 1;
  localparam int BIND_TC_LSB = 21;

  typedef enum logic [1:0] {
    BANK_SHARED = 2'd0,
    BANK_VPE    = 2'd1,
    BANK_THREAD = 2'd2
  } bank_e;

  typedef struct packed {
    logic              wrStrobe;
    logic              rawMode;
    logic [SLOT_W-1:0] wrSlot;
    logic [DW-1:0]     wrMask;
  } wr_ctl_t;

  function automatic int vpeFieldW(input int nv);
    return (nv > 1) ? $clog2(nv) : 1;
  endfunction

  // register id -> flat index {regNum, sel}
  function automatic logic [IDX_W-1:0] regIndex(input int r);
    case (r)
      0: return {5'd0, 3'd0};
      1: return {5'd2, 3'd2};
      2: return {5'd12, 3'd0};
      3: return {5'd12, 3'd1};
      4: return {5'd15, 3'd1};
      5: return {5'd16, 3'd0};
      6: return {5'd16, 3'd1};
      default: return '0;
    endcase
  endfunction

  function automatic bank_e regBank(input int r);
    case (r)
      1, 2:    return BANK_THREAD;
      4, 5:    return BANK_VPE;
      default: return BANK_SHARED;
    endcase
  endfunction

  function automatic logic [DW-1:0] regMask(input int r, input int nv);
    case (r)
      0: return 32'h7FFF_FFFF;
      1: return (DW'(1) << vpeFieldW(nv)) - DW'(1);
      2: return 32'hFF78_FF17;
      3: return 32'h0000_03E0;
      4: return 32'h3FFF_F000;
      5: return 32'h7FFF_0007;
      default: return '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] regReset(input int r, input int copy);
    case (r)
      1: return DW'(copy) << BIND_TC_LSB;
      2: return 32'h0040_0004;
      4: return 32'h8000_0000;
      default: return '0;
    endcase
  endfunction

  function automatic int regCopies(input int r, input int nt, input int nv);
    case (regBank(r))
      BANK_THREAD: return nt;
      BANK_VPE:    return nv;
      default:     return 1;
    endcase
  endfunction

  function automatic int slotBase(input int r, input int nt, input int nv);
    int acc = 0;
    for (int k = 0; k < NUM_REGS; k++)
      if (k < r) acc += regCopies(k, nt, nv);
    return acc;
  endfunction

  function automatic int slotReg(input int s, input int nt, input int nv);
    int res = 0;
    for (int k = 0; k < NUM_REGS; k++)
      if (s >= slotBase(k, nt, nv)) res = k;
    return res;
  endfunction

  function automatic int lookupReg(input logic [IDX_W-1:0] idx);
    int res = -1;
    for (int k = 0; k < NUM_REGS; k++)
      if (regIndex(k) == idx) res = k;
    return res;
  endfunction
endpackage

// File: rtl/ctlrf_ctrl.sv
module ctlrf_ctrl
  import ctlrf_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int NUM_VPES = 1,
  parameter int TID_W = 1,
  parameter int VPE_W = 1
) (
  input  logic [TID_W-1:0]                   rdThread,
  input  logic [IDX_W-1:0]                   rdIdx,
  input  logic                               wrEn,
  input  logic                               wrRaw,
  input  logic [TID_W-1:0]                   wrThread,
  input  logic [IDX_W-1:0]                   wrIdx,
  input  logic [NUM_THREADS-1:0][VPE_W-1:0]  bindVpe,
  output logic                               rdHit,
  output logic [SLOT_W-1:0]                  rdSlot,
  output wr_ctl_t                            wrCtl
);
  // returns {hit, slot}
  function automatic logic [SLOT_W:0] resolve(input logic [IDX_W-1:0] idx,
                                              input logic [TID_W-1:0] tid,
                                              input logic [NUM_THREADS-1:0][VPE_W-1:0] bv);
    int r;
    int copy;
    logic hit;
    r = lookupReg(idx);
    hit = (r >= 0) && (int'(tid) < NUM_THREADS);
    copy = 0;
    if (hit) begin
      case (regBank(r))
        BANK_THREAD: copy = int'(tid);
        BANK_VPE: begin
          copy = int'(bv[tid]);
          if (copy >= NUM_VPES) copy = 0;
        end
        default: copy = 0;
      endcase
    end
    return {hit, hit ? SLOT_W'(slotBase(r, NUM_THREADS, NUM_VPES) + copy) : '0};
  endfunction

  logic [SLOT_W:0] rdRes;
  logic [SLOT_W:0] wrRes;

  always_comb begin
    rdRes = resolve(rdIdx, rdThread, bindVpe);
    wrRes = resolve(wrIdx, wrThread, bindVpe);
    rdHit = rdRes[SLOT_W];
    rdSlot = rdRes[SLOT_W-1:0];
    wrCtl.wrStrobe = wrEn && wrRes[SLOT_W];
    wrCtl.rawMode = wrRaw;
    wrCtl.wrSlot = wrRes[SLOT_W-1:0];
    wrCtl.wrMask = regMask(lookupReg(wrIdx), NUM_VPES);
  end
endmodule

// File: rtl/ctlrf_dp.sv
module ctlrf_dp
  import ctlrf_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int NUM_VPES = 1,
  parameter int VPE_W = 1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  wr_ctl_t                            wrCtl,
  input  logic [DW-1:0]                      wrData,
  input  logic                               rdHit,
  input  logic [SLOT_W-1:0]                  rdSlot,
  output logic [DW-1:0]                      rdData,
  output logic [NUM_THREADS-1:0][VPE_W-1:0]  bindVpe
);
  localparam int NSLOTS = slotBase(NUM_REGS, NUM_THREADS, NUM_VPES);
  localparam int BIND_BASE = slotBase(BIND_REG, NUM_THREADS, NUM_VPES);

  logic [DW-1:0] slotQ [NSLOTS];

  for (genvar s = 0; s < NSLOTS; s++) begin : g_slot
    localparam int REG_ID = slotReg(s, NUM_THREADS, NUM_VPES);
    localparam int COPY = s - slotBase(REG_ID, NUM_THREADS, NUM_VPES);
    localparam logic [DW-1:0] RST_VAL = regReset(REG_ID, COPY);
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        q <= RST_VAL;
      end else if (wrCtl.wrStrobe && wrCtl.wrSlot == SLOT_W'(s)) begin
        if (wrCtl.rawMode) q <= wrData;
        else q <= (wrData & wrCtl.wrMask) | (q & ~wrCtl.wrMask);
      end
    end
    assign slotQ[s] = q;
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_bind
    assign bindVpe[t] = slotQ[BIND_BASE + t][VPE_W-1:0];
  end

  always_comb begin
    rdData = '0;
    for (int s = 0; s < NSLOTS; s++)
      if (rdHit && rdSlot == SLOT_W'(s)) rdData = slotQ[s];
  end
endmodule

// File: rtl/ctlrf_top.sv
module ctlrf_top
  import ctlrf_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int NUM_VPES = 1,
  localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [TID_W-1:0] rdThread,
  input  logic [4:0]       rdRegNum,
  input  logic [2:0]       rdSel,
  output logic [31:0]      rdData,
  input  logic             wrEn,
  input  logic             wrRaw,
  input  logic [TID_W-1:0] wrThread,
  input  logic [4:0]       wrRegNum,
  input  logic [2:0]       wrSel,
  input  logic [31:0]      wrData
);
  localparam int VPE_W = vpeFieldW(NUM_VPES);

  wr_ctl_t wrCtl;
  logic rdHit;
  logic [SLOT_W-1:0] rdSlot;
  logic [NUM_THREADS-1:0][VPE_W-1:0] bindVpe;

  ctlrf_ctrl #(
    .NUM_THREADS(NUM_THREADS), .NUM_VPES(NUM_VPES), .TID_W(TID_W), .VPE_W(VPE_W)
  ) u_ctrl (
    .rdThread(rdThread), .rdIdx({rdRegNum, rdSel}),
    .wrEn(wrEn), .wrRaw(wrRaw), .wrThread(wrThread), .wrIdx({wrRegNum, wrSel}),
    .bindVpe(bindVpe), .rdHit(rdHit), .rdSlot(rdSlot), .wrCtl(wrCtl)
  );

  ctlrf_dp #(
    .NUM_THREADS(NUM_THREADS), .NUM_VPES(NUM_VPES), .VPE_W(VPE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wrCtl(wrCtl), .wrData(wrData),
    .rdHit(rdHit), .rdSlot(rdSlot), .rdData(rdData), .bindVpe(bindVpe)
  );
endmodule

// File: rtl/ctlrf_chk.sv
module ctlrf_chk
  import ctlrf_pkg::*;
#(
  parameter int NUM_THREADS = 2,
  parameter int NUM_VPES = 1,
  parameter int TID_W = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic [TID_W-1:0] rdThread,
  input logic [4:0]       rdRegNum,
  input logic [2:0]       rdSel,
  input logic [31:0]      rdData,
  input logic             wrEn,
  input logic             wrRaw,
  input logic [TID_W-1:0] wrThread,
  input logic [4:0]       wrRegNum,
  input logic [2:0]       wrSel,
  input logic [31:0]      wrData
);
  logic [7:0] rIdx, wIdx;
  logic [31:0] wMask;
  logic wImpl, rImpl, sameAddr, pastValid;
  localparam logic [7:0] RO_IDX = {5'd16, 3'd1};

  assign rIdx = {rdRegNum, rdSel};
  assign wIdx = {wrRegNum, wrSel};
  assign wMask = regMask(lookupReg(wIdx), NUM_VPES);
  assign wImpl = (lookupReg(wIdx) >= 0) && (int'(wrThread) < NUM_THREADS);
  assign rImpl = (lookupReg(rIdx) >= 0) && (int'(rdThread) < NUM_THREADS);
  assign sameAddr = (rIdx == wIdx) && (rdThread == wrThread);

  always_ff @(posedge clk) begin
    if (!rstN) pastValid <= 1'b0;
    else pastValid <= 1'b1;
  end

  // R3: masked merge seen on the next cycle
  a_r3_masked_merge: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(wrEn && !wrRaw && sameAddr && wImpl) && $stable(rIdx) && $stable(rdThread))
    |-> rdData == (($past(wrData) & $past(wMask)) | ($past(rdData) & ~$past(wMask))));

  // R4: raw write stored whole
  a_r4_raw_store: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && $past(wrEn && wrRaw && sameAddr && wImpl) && $stable(rIdx) && $stable(rdThread))
    |-> rdData == $past(wrData));

  // R8: without a write the read value holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && !$past(wrEn) && $stable(rIdx) && $stable(rdThread)) |-> $stable(rdData));

  // R9: unimplemented index or thread reads zero
  a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (!rstN)
    !rImpl |-> rdData == 32'h0);

  // R10: read-only register only changes through the raw path
  a_r10_readonly: assert property (@(posedge clk) disable iff (!rstN)
    (pastValid && rIdx == RO_IDX && $stable(rIdx) && rImpl && $past(rImpl) && !$past(wrEn && wrRaw))
    |-> $stable(rdData));
endmodule

bind ctlrf_top ctlrf_chk #(
  .NUM_THREADS(NUM_THREADS), .NUM_VPES(NUM_VPES), .TID_W(TID_W)
) u_chk (
  .clk(clk), .rstN(rstN), .rdThread(rdThread), .rdRegNum(rdRegNum), .rdSel(rdSel),
  .rdData(rdData), .wrEn(wrEn), .wrRaw(wrRaw), .wrThread(wrThread),
  .wrRegNum(wrRegNum), .wrSel(wrSel), .wrData(wrData)
);

// File: tb/ctlrf_top_bench.sv
module ctlrf_top_bench;
  localparam int NT = 4;
  localparam int NV = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] rdThread = '0, wrThread = '0;
  logic [4:0] rdRegNum = '0, wrRegNum = '0;
  logic [2:0] rdSel = '0, wrSel = '0;
  logic [31:0] rdData, wrData = '0;
  logic wrEn = 1'b0, wrRaw = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [31:0] mdl [7][NT];

  always #4 clk = ~clk;

  ctlrf_top #(.NUM_THREADS(NT), .NUM_VPES(NV)) u_ctlrf_top (
    .clk(clk), .rstN(rstN), .rdThread(rdThread), .rdRegNum(rdRegNum), .rdSel(rdSel),
    .rdData(rdData), .wrEn(wrEn), .wrRaw(wrRaw), .wrThread(wrThread),
    .wrRegNum(wrRegNum), .wrSel(wrSel), .wrData(wrData)
  );

  // bench ids: 0 slotIdx, 1 threadBind, 2 machState, 3 intCfg, 4 vecBase, 5 cfgMain, 6 cfgRo
  function automatic int bIdx(input int r);
    case (r)
      0: return 0;       1: return 2*8+2;   2: return 12*8;   3: return 12*8+1;
      4: return 15*8+1;  5: return 16*8;    6: return 16*8+1;
      default: return 255;
    endcase
  endfunction

  function automatic int bLookup(input int idx);
    for (int r = 0; r < 7; r++) if (bIdx(r) == idx) return r;
    return -1;
  endfunction

  function automatic logic [31:0] bMask(input int r);
    case (r)
      0: return 32'h7FFFFFFF; 1: return 32'h1;        2: return 32'hFF78FF17;
      3: return 32'h000003E0; 4: return 32'h3FFFF000; 5: return 32'h7FFF0007;
      default: return 32'h0;
    endcase
  endfunction

  function automatic int bCopy(input int r, input int t);
    if (r == 1 || r == 2) return t;
    if (r == 4 || r == 5) return int'(mdl[1][t][0]);
    return 0;
  endfunction

  function automatic string bTag(input int r);
    if (r < 0) return "R9";
    if (r == 1 || r == 2) return "R5";
    if (r == 4 || r == 5) return "R6";
    return "R7";
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // one cycle: drive, check the read before the edge, then commit the model
  task automatic op(input string tag, input int rT, input int rIdx,
                    input bit wE, input bit wR, input int wT, input int wI, input logic [31:0] wD);
    int rr, wr, wc;
    logic [31:0] exp;
    @(negedge clk);
    rdThread = 2'(rT); rdRegNum = 5'(rIdx >> 3); rdSel = 3'(rIdx);
    wrEn = wE; wrRaw = wR; wrThread = 2'(wT); wrRegNum = 5'(wI >> 3); wrSel = 3'(wI); wrData = wD;
    #1;
    rr = bLookup(rIdx);
    exp = (rr < 0) ? 32'h0 : mdl[rr][bCopy(rr, rT)];
    chk(tag, rdData, exp);
    wr = bLookup(wI);
    wc = (wr < 0) ? 0 : bCopy(wr, wT);
    @(posedge clk);
    if (wE && wr >= 0) begin
      if (wR) mdl[wr][wc] = wD;
      else mdl[wr][wc] = (wD & bMask(wr)) | (mdl[wr][wc] & ~bMask(wr));
    end
  endtask

  task automatic rd(input string tag, input int t, input int idx);
    op(tag, t, idx, 1'b0, 1'b0, 0, 0, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL R8 watchdog got=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int r = 0; r < 7; r++)
      for (int t = 0; t < NT; t++)
        mdl[r][t] = (r == 1) ? (32'(t) << 21) : (r == 2) ? 32'h00400004 :
                    (r == 4) ? 32'h80000000 : 32'h0;
    void'($urandom(32'd24681));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset values
    for (int t = 0; t < NT; t++) begin
      rd("R1", t, bIdx(2));
      rd("R1", t, bIdx(1));
      rd("R1", t, bIdx(4));
      rd("R1", t, bIdx(0));
    end
    // R2 neighbouring selects are distinct registers
    op("R2", 0, bIdx(3), 1'b1, 1'b0, 0, bIdx(3), 32'hFFFFFFFF);
    rd("R2", 0, bIdx(3));
    rd("R2", 0, bIdx(2));
    // R3 masked write, R8 same-cycle read returns old value
    op("R8", 0, bIdx(2), 1'b1, 1'b0, 0, bIdx(2), 32'hFFFFFFFF);
    rd("R3", 0, bIdx(2));
    op("R8", 0, bIdx(2), 1'b1, 1'b0, 0, bIdx(2), 32'h0);
    rd("R3", 0, bIdx(2));
    op("R3", 0, bIdx(5), 1'b1, 1'b0, 0, bIdx(5), 32'hA5A5A5A5);
    rd("R3", 0, bIdx(5));
    // R10 read-only ignores masked write, R4 raw write lands
    op("R10", 0, bIdx(6), 1'b1, 1'b0, 2, bIdx(6), 32'hFFFFFFFF);
    rd("R10", 0, bIdx(6));
    op("R4", 0, bIdx(6), 1'b1, 1'b1, 1, bIdx(6), 32'hDEADBEEF);
    rd("R4", 0, bIdx(6));
    op("R4", 1, bIdx(2), 1'b1, 1'b1, 1, bIdx(2), 32'h12345678);
    rd("R4", 1, bIdx(2));
    // R5 per-thread isolation
    op("R5", 3, bIdx(2), 1'b1, 1'b0, 2, bIdx(2), 32'h0F0F0F0F);
    rd("R5", 3, bIdx(2));
    rd("R5", 2, bIdx(2));
    // R6 processor copy through binding field
    op("R6", 1, bIdx(1), 1'b1, 1'b0, 1, bIdx(1), 32'hFFFFFFFF);
    rd("R6", 1, bIdx(1));
    op("R6", 1, bIdx(4), 1'b1, 1'b0, 1, bIdx(4), 32'hFFFFFFFF);
    rd("R6", 1, bIdx(4));
    rd("R6", 0, bIdx(4));
    op("R6", 3, bIdx(1), 1'b1, 1'b1, 3, bIdx(1), 32'h00000001);
    rd("R6", 3, bIdx(4));
    // R7 shared register
    op("R7", 0, bIdx(0), 1'b1, 1'b0, 2, bIdx(0), 32'hFFFFFFFF);
    rd("R7", 0, bIdx(0));
    rd("R7", 3, bIdx(0));
    // R9 unimplemented indices
    op("R9", 0, 12*8+2, 1'b1, 1'b1, 0, 12*8+2, 32'hFFFFFFFF);
    rd("R9", 0, 12*8+2);
    rd("R9", 2, 255);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int k, ri, wi, rt;
      k = $urandom_range(0, 7);
      ri = (k < 7) ? bIdx(k) : $urandom_range(0, 255);
      k = $urandom_range(0, 7);
      wi = (k < 7) ? bIdx(k) : $urandom_range(0, 255);
      rt = $urandom_range(0, NT-1);
      op(bTag(bLookup(ri)), rt, ri, 1'($urandom_range(0, 1)), ($urandom_range(0, 3) == 0),
         $urandom_range(0, NT-1), wi, $urandom());
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule